// File: doc/BRIEF.md
# Write Stream Discard Controller

This block decides, cycle by cycle, whether the write data stream leaving a write FIFO ahead of an external memory should be thrown away instead of stored. Between memory accesses the FIFO keeps filling from its source. If the next write access is late, the FIFO would overflow. A controller can therefore request a discard while no access is in progress. The block then raises its flush-enable output, and a separate gate downstream drops the words.

When a write access is later started, discarding does not stop at once. It stops on the next stream word that forms a proper resume point, so the stored data begins on a clean boundary. A parameter selects the resume point: any valid word, a start-of-packet word, or a sync-marked word. An optional channel window can narrow the resume point to words from a chosen range of channels. A read access leaves the discard state unchanged. The present state is exported as a 2-bit code for monitoring.

Top module: `wr_discard_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the state code is 00 (pass) and flush_en is low.
- R2: In pass state, a flush_req pulse while acc_done is high moves the block to discard state (code 01) on the next cycle, with flush_en high. No stream boundary is awaited.
- R3: A flush_req pulse while acc_done is low has no effect. The state code stays 00 and flush_en stays low.
- R4: In discard state, a read access start (acc_start high with acc_is_write low) or another flush_req leaves the state code at 01 with flush_en high.
- R5: In discard state, a write access start moves the block to resume-wait state (code 10) on the next cycle. flush_en stays high until a qualifying word is seen.
- R6: In resume-wait state, flush_en is low in the same cycle that a qualifying word is presented, so that word is kept. The state code is 00 on the next cycle.
- R7: A word qualifies only when strm_valid is high and the mode condition holds. In RESUME_ON = BND_ANY_VALID any valid word qualifies. In BND_PKT_START strm_sop must also be high. In BND_SYNC_MARK strm_sync must also be high. A valid word that fails the condition keeps flush_en high and the state at 10.
- R8: With CHAN_FILTER_EN set, a word qualifies only if strm_chan is within CHAN_FIRST to CHAN_FIRST+CHAN_COUNT-1 inclusive. A word outside that range keeps flush_en high.
- R9: In pass state, a flush_req with acc_done high in the same cycle as a write access start moves the block directly to code 10.
- R10: The state code is never 11. In pass state, stream words and access starts without a recognised flush_req leave the state at 00 with flush_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_start | input | 1 | One-cycle pulse that starts a memory access |
| acc_is_write | input | 1 | Access type qualifying acc_start: 1 for write, 0 for read |
| flush_req | input | 1 | One-cycle request to begin discarding |
| acc_done | input | 1 | High while no access is in progress |
| strm_valid | input | 1 | Write stream word valid |
| strm_sop | input | 1 | Write stream start-of-packet marker |
| strm_sync | input | 1 | Write stream sync marker |
| strm_chan | input | CHAN_W | Write stream channel number |
| flush_en | output | 1 | High while the write stream must be discarded |
| state_mon | output | 2 | State code: 00 pass, 01 discard, 10 resume-wait |

## Verification
The hardest situation to reach from the ports is resume-wait state combined with a word that almost qualifies. Examples are a start-of-packet word on a channel just outside the window, or a valid word that lacks the sync marker. Reaching this state takes three ordered events: a flush request while done is high, then a write start, then the near-miss word. The bench reaches it in two ways. Directed sequences walk the block into resume-wait and then present each near-miss word in turn. Seeded random stimulus uses biased probabilities so that flush requests, write starts and marker bits recur often enough to revisit that state many times under each of three mode settings.

// File: rtl/wdc_pkg.sv
// Package: shared encodings for the write stream discard controller.
// Assumes: the state codes are observed externally and must stay fixed.
package wdc_pkg;

    // Controller states; the encoding is the exported monitor code.
    typedef enum logic [1:0] {
        WDC_PASS    = 2'b00,
        WDC_DISCARD = 2'b01,
        WDC_HOLD    = 2'b10
    } wdc_state_e;

    // Stream boundary on which discarding ends after a write start.
    typedef enum logic [1:0] {
        BND_ANY_VALID = 2'b00,
        BND_PKT_START = 2'b01,
        BND_SYNC_MARK = 2'b10
    } wdc_bound_e;

endpackage

// File: rtl/wdc_chan_window.sv
// Module: wdc_chan_window
// Flags whether a stream channel number lies inside a configured window.
// Assumes: CHAN_COUNT >= 1 and the window fits in CHAN_W bits; when the
// filter is disabled every channel is accepted.
module wdc_chan_window #(
    parameter int CHAN_W     = 4,
    parameter bit ENABLE     = 1'b0,
    parameter int CHAN_FIRST = 4,
    parameter int CHAN_COUNT = 4
) (
    input  logic [CHAN_W-1:0] chan,
    output logic              in_window
);
    localparam int             LAST_CH = CHAN_FIRST + CHAN_COUNT - 1;
    localparam logic [CHAN_W:0] LO_V   = (CHAN_W+1)'(CHAN_FIRST);
    localparam logic [CHAN_W:0] HI_V   = (CHAN_W+1)'(LAST_CH);

    logic [CHAN_W:0] chan_ext;
    logic            above_lo;
    logic            below_hi;

    assign chan_ext = {1'b0, chan};

    // Lower bound check; a zero lower bound needs no comparator.
    generate
        if (CHAN_FIRST == 0) begin : g_lo_free
            assign above_lo = 1'b1;
        end else begin : g_lo_cmp
            assign above_lo = (chan_ext >= LO_V);
        end
    endgenerate

    // Upper bound check of the window.
    assign below_hi = (chan_ext <= HI_V);

    // Select filtered or pass-all result.
    assign in_window = ENABLE ? (above_lo && below_hi) : 1'b1;

endmodule

// File: rtl/wdc_boundary_detect.sv
// Module: wdc_boundary_detect
// Recognises a stream word on which discarding may end, per the chosen mode.
// Assumes: the marker inputs are only meaningful when valid is high.
module wdc_boundary_detect
    import wdc_pkg::*;
#(
    parameter wdc_bound_e RESUME_ON = BND_PKT_START
) (
    input  logic valid,
    input  logic sop,
    input  logic sync,
    input  logic in_window,
    output logic hit
);
    logic mode_ok;

    // Mode-specific marker condition.
    always_comb begin
        unique case (RESUME_ON)
            BND_ANY_VALID: mode_ok = 1'b1 | (sop & sync);
            BND_PKT_START: mode_ok = sop;
            BND_SYNC_MARK: mode_ok = sync;
            default:       mode_ok = 1'b0;
        endcase
    end

    // Qualifying word: valid, marker condition met, channel accepted.
    assign hit = valid && mode_ok && in_window;

endmodule

// File: rtl/wdc_fsm.sv
// Module: wdc_fsm
// Three-state controller: pass, discard, and resume-wait. Flush requests are
// honoured only while no access is in progress; discard ends on a boundary.
// Assumes: acc_start and flush_req are single-cycle pulses.
module wdc_fsm
    import wdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_start,
    input  logic       acc_is_write,
    input  logic       flush_req,
    input  logic       acc_done,
    input  logic       hit,
    output logic [1:0] state_code,
    output logic       flush_en
);
    wdc_state_e state_q;
    wdc_state_e state_d;
    logic       wr_start;
    logic       req_seen;

    assign wr_start = acc_start && acc_is_write;
    assign req_seen = flush_req && acc_done;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WDC_PASS:    if (req_seen) state_d = wr_start ? WDC_HOLD : WDC_DISCARD;
            WDC_DISCARD: if (wr_start) state_d = WDC_HOLD;
            WDC_HOLD:    if (hit)      state_d = WDC_PASS;
            default:     state_d = WDC_PASS;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WDC_PASS;
        else        state_q <= state_d;
    end

    // Discard while in discard state, or while waiting until the boundary word.
    assign flush_en   = (state_q == WDC_DISCARD) || ((state_q == WDC_HOLD) && !hit);
    assign state_code = state_q;

    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WDC_PASS && flush_req && !acc_done) |=> (state_q == WDC_PASS)); // R3
    AST_REQ_ENTERS_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WDC_PASS && req_seen && !wr_start) |=> (state_q == WDC_DISCARD)); // R2
    AST_READ_KEEPS_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WDC_DISCARD && !wr_start) |=> (state_q == WDC_DISCARD && flush_en)); // R4
    AST_WRITE_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WDC_DISCARD && wr_start) |=> (state_q == WDC_HOLD)); // R5
    AST_BOUNDARY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WDC_HOLD && hit) |=> (state_q == WDC_PASS)); // R6
    AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WDC_PASS && req_seen && wr_start) |=> (state_q == WDC_HOLD)); // R9

endmodule

// File: rtl/wr_discard_ctrl.sv
// Module: wr_discard_ctrl (top)
// Decides when the write stream from the write FIFO is discarded, and when a
// pending write access may resume storing it.
// Assumes: all inputs are synchronous to clk; the discard gate, FIFO and
// memory access logic sit outside this block.
module wr_discard_ctrl
    import wdc_pkg::*;
#(
    parameter wdc_bound_e RESUME_ON      = BND_PKT_START,
    parameter bit         CHAN_FILTER_EN = 1'b0,
    parameter int         CHAN_W         = 4,
    parameter int         CHAN_FIRST     = 4,
    parameter int         CHAN_COUNT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic              acc_is_write,
    input  logic              flush_req,
    input  logic              acc_done,
    input  logic              strm_valid,
    input  logic              strm_sop,
    input  logic              strm_sync,
    input  logic [CHAN_W-1:0] strm_chan,
    output logic              flush_en,
    output logic [1:0]        state_mon
);
    logic chan_ok;
    logic bnd_hit;

    // Channel window filter.
    wdc_chan_window #(
        .CHAN_W     (CHAN_W),
        .ENABLE     (CHAN_FILTER_EN),
        .CHAN_FIRST (CHAN_FIRST),
        .CHAN_COUNT (CHAN_COUNT)
    ) u_window (
        .chan      (strm_chan),
        .in_window (chan_ok)
    );

    // Resume boundary recognition.
    wdc_boundary_detect #(
        .RESUME_ON (RESUME_ON)
    ) u_bound (
        .valid     (strm_valid),
        .sop       (strm_sop),
        .sync      (strm_sync),
        .in_window (chan_ok),
        .hit       (bnd_hit)
    );

    // Control state machine.
    wdc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_start    (acc_start),
        .acc_is_write (acc_is_write),
        .flush_req    (flush_req),
        .acc_done     (acc_done),
        .hit          (bnd_hit),
        .state_code   (state_mon),
        .flush_en     (flush_en)
    );

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_mon != 2'b11); // R10
    AST_PASS_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_mon == 2'b00) |-> !flush_en); // R1
    AST_INVALID_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_mon == 2'b10 && !strm_valid) |-> flush_en); // R7
    AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (CHAN_FILTER_EN && state_mon == 2'b10 && !chan_ok) |-> flush_en); // R8

endmodule

// File: tb/wr_discard_ctrl_tb_top.sv
`timescale 1ns/1ps
module wr_discard_ctrl_tb_top;
    import wdc_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_start = 0, acc_is_write = 0, flush_req = 0, acc_done = 0;
    logic       strm_valid = 0, strm_sop = 0, strm_sync = 0;
    logic [3:0] strm_chan = '0;
    logic       fl [3];
    logic [1:0] sm [3];
    int         n_checks = 0;
    int         n_fail   = 0;
    bit         finished = 0;
    logic [1:0] exp_st [3];

    always #2.5 clk = ~clk;  // 200 MHz

    // dut 0: start-of-packet with channel window 2..4; dut 1: any valid; dut 2: sync
    wr_discard_ctrl #(.RESUME_ON(BND_PKT_START), .CHAN_FILTER_EN(1'b1), .CHAN_W(4),
                      .CHAN_FIRST(2), .CHAN_COUNT(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_is_write(acc_is_write),
        .flush_req(flush_req), .acc_done(acc_done), .strm_valid(strm_valid),
        .strm_sop(strm_sop), .strm_sync(strm_sync), .strm_chan(strm_chan),
        .flush_en(fl[0]), .state_mon(sm[0]));
    wr_discard_ctrl #(.RESUME_ON(BND_ANY_VALID), .CHAN_FILTER_EN(1'b0), .CHAN_W(4),
                      .CHAN_FIRST(2), .CHAN_COUNT(3)) dut_val_i (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_is_write(acc_is_write),
        .flush_req(flush_req), .acc_done(acc_done), .strm_valid(strm_valid),
        .strm_sop(strm_sop), .strm_sync(strm_sync), .strm_chan(strm_chan),
        .flush_en(fl[1]), .state_mon(sm[1]));
    wr_discard_ctrl #(.RESUME_ON(BND_SYNC_MARK), .CHAN_FILTER_EN(1'b0), .CHAN_W(4),
                      .CHAN_FIRST(2), .CHAN_COUNT(3)) dut_syn_i (
        .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_is_write(acc_is_write),
        .flush_req(flush_req), .acc_done(acc_done), .strm_valid(strm_valid),
        .strm_sop(strm_sop), .strm_sync(strm_sync), .strm_chan(strm_chan),
        .flush_en(fl[2]), .state_mon(sm[2]));

    // Expected qualifying-word decision for dut k (R7, R8).
    function automatic logic exp_hit(int k);
        logic c;
        case (k)
            0:       c = strm_sop && (strm_chan >= 4'd2) && (strm_chan <= 4'd4);
            1:       c = 1'b1;
            default: c = strm_sync;
        endcase
        return strm_valid && c;
    endfunction

    function automatic logic [1:0] exp_next(logic [1:0] st, int k);
        case (st)
            2'b00: return (flush_req && acc_done) ?
                          ((acc_start && acc_is_write) ? 2'b10 : 2'b01) : 2'b00;
            2'b01: return (acc_start && acc_is_write) ? 2'b10 : 2'b01;
            default: return exp_hit(k) ? 2'b00 : 2'b10;
        endcase
    endfunction

    function automatic logic exp_flush(logic [1:0] st, int k);
        return (st == 2'b01) || ((st == 2'b10) && !exp_hit(k));
    endfunction

    function automatic string pick_tag(logic [1:0] st, int k);
        if (st == 2'b00) begin
            if (flush_req && acc_done && acc_start && acc_is_write) return "R9";
            if (flush_req) return acc_done ? "R2" : "R3";
            return "R10";
        end
        if (st == 2'b01) return (acc_start && acc_is_write) ? "R5" : "R4";
        if (k == 0 && strm_valid && strm_sop) return "R8";
        return exp_hit(k) ? "R6" : "R7";
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs, compare outputs, advance the model.
    task automatic step(logic st, logic wr, logic rq, logic dn, logic v,
                        logic sp, logic sy, logic [3:0] ch, string tag);
        @(negedge clk);
        acc_start = st; acc_is_write = wr; flush_req = rq; acc_done = dn;
        strm_valid = v; strm_sop = sp; strm_sync = sy; strm_chan = ch;
        #1;
        for (int k = 0; k < 3; k++) begin
            string t;
            t = (tag == "") ? pick_tag(exp_st[k], k) : tag;
            check(sm[k] == exp_st[k], t, $sformatf("state dut%0d", k), sm[k], exp_st[k]);
            check(fl[k] == exp_flush(exp_st[k], k), t, $sformatf("flush dut%0d", k),
                  fl[k], exp_flush(exp_st[k], k));
        end
        for (int k = 0; k < 3; k++) exp_st[k] = exp_next(exp_st[k], k);
    endtask

    initial begin
        void'($urandom(32'd2417));
        for (int k = 0; k < 3; k++) exp_st[k] = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            check(sm[k] == 2'b00, "R1", "reset state", sm[k], 0);
            check(fl[k] == 1'b0, "R1", "reset flush", fl[k], 0);
        end
        rst_n = 1'b1;
        // directed corners
        step(1, 1, 0, 1, 1, 1, 1, 4'd3, "R10");  // starts and words in pass state
        step(0, 0, 1, 0, 1, 0, 0, 4'd0, "R10");  // request while busy
        step(0, 0, 0, 0, 0, 0, 0, 4'd0, "R3");   // still pass
        step(0, 0, 1, 1, 0, 0, 0, 4'd0, "R3");   // request while done
        step(1, 0, 0, 0, 1, 1, 1, 4'd3, "R2");   // discarding; read start
        step(0, 0, 1, 1, 0, 0, 0, 4'd0, "R4");   // still discarding; extra request
        step(1, 1, 0, 0, 0, 0, 0, 4'd0, "R4");   // write start
        step(0, 0, 0, 0, 1, 0, 0, 4'd3, "R7");   // plain valid: only any-valid dut resumes
        step(0, 0, 0, 0, 1, 1, 0, 4'd7, "R8");   // sop outside window
        step(0, 0, 0, 0, 1, 1, 0, 4'd1, "R8");   // sop below window
        step(0, 0, 0, 0, 0, 1, 1, 4'd3, "R7");   // markers without valid
        step(0, 0, 0, 0, 1, 1, 1, 4'd4, "R6");   // qualifies for sop and sync duts
        step(1, 1, 1, 1, 0, 0, 0, 4'd0, "R6");   // back in pass: direct hold request
        step(0, 0, 0, 0, 0, 0, 0, 4'd0, "R9");   // in resume-wait
        step(0, 0, 0, 0, 1, 1, 1, 4'd2, "R6");   // release at window edge
        step(0, 0, 0, 0, 0, 0, 0, 4'd0, "R6");
        // seeded random stimulus with biased rates
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 9) == 0, $urandom_range(0, 1),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 1),
                 $urandom_range(0, 9) < 7, $urandom_range(0, 4) == 0,
                 $urandom_range(0, 5) == 0, 4'($urandom_range(0, 15)), "");
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule